// File: doc/BRIEF.md
# Priority Task Dispatcher for Packet Processors

This block hands packet-processing work to a small pool of packet-processing units. A queue manager tells it, one event per cycle, that a complete packet has been stored for one of the input flows. The dispatcher keeps a pending count per flow. Each cycle it picks one eligible flow and one processing unit with buffer room, and issues a header-forward command. The command names the flow, the target unit and the half of that unit's two-half local buffer that the queue manager must fill.

Flow choice has two levels. Only flows in the highest non-empty priority level compete. Within that level, a weighted round robin lets each flow take up to its weight in back-to-back dispatches. Each unit's buffer has two halves, so a unit can hold one packet in progress and one prefetched. That lets the header transfer for the next packet overlap the current work.

When a unit reports completion, the block frees that unit's oldest half. It then issues an output-enqueue command that carries the source flow together with the output interface and priority reported by the unit.

Top module: `pkt_task_dispatch`

## Requirements
- R1: An arrival event taken at clock edge k is counted as pending, and the matching forward command (`fwd_valid`=1, `fwd_flow` = that flow) is visible after edge k+1 when a unit has room; no command is issued without a pending request.
- R2: Only flows whose configured priority equals the highest priority among flows with pending work may be dispatched; priority value 3 is the most urgent and 0 the least.
- R3: Within the top level, the last served flow keeps being chosen while it stays eligible, for up to its weight in consecutive dispatches (weight 0 counts as 1). After that, the next eligible flow in ascending circular index order after it is served. After reset the search starts at flow 0.
- R4: The target unit is the lowest-index unit with both halves free. If there is none, it is the lowest-index unit with exactly one half free. No dispatch occurs while every unit is full. `unit_busy[u]` is 1 exactly when both halves of unit u are occupied.
- R5: Each unit fills its halves alternately, starting with half 0 after reset; `fwd_half` names the half being filled.
- R6: A completion for a unit holding at least one packet frees its oldest half. After the same edge, one enqueue command appears carrying that unit, that half, the flow dispatched into it, and the reported output interface and priority.
- R7: A completion for a unit holding no packet is ignored: no enqueue command follows and no state changes.
- R8: A per-flow pending count saturates at 15 (2^PEND_W-1). An arrival for a flow already at 15 is dropped and sets the sticky `pend_ovf`, which stays 1 until reset.
- R9: During and right after reset, there are no forward or enqueue commands, all units read not busy, and `pend_ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_prio | input | NUM_FLOWS*PRIO_W | Per-flow priority, flow f at bits [f*PRIO_W +: PRIO_W] |
| cfg_weight | input | NUM_FLOWS*WGT_W | Per-flow burst weight, flow f at bits [f*WGT_W +: WGT_W] |
| arr_valid | input | 1 | Packet-arrival event |
| arr_flow | input | log2(NUM_FLOWS) | Input flow of the arrival |
| done_valid | input | 1 | Completion report from a unit |
| done_unit | input | log2(NUM_UNITS) | Unit reporting completion |
| done_oif | input | OIF_W | Output interface chosen by the unit |
| done_oprio | input | PRIO_W | Output priority chosen by the unit |
| fwd_valid | output | 1 | Header-forward command valid |
| fwd_flow | output | log2(NUM_FLOWS) | Flow whose head packet is forwarded |
| fwd_unit | output | log2(NUM_UNITS) | Target processing unit |
| fwd_half | output | 1 | Target half of the unit buffer |
| enq_valid | output | 1 | Output-enqueue command valid |
| enq_unit | output | log2(NUM_UNITS) | Unit whose packet is finished |
| enq_half | output | 1 | Buffer half being released |
| enq_flow | output | log2(NUM_FLOWS) | Input flow the packet came from |
| enq_oif | output | OIF_W | Output interface for the enqueue |
| enq_oprio | output | PRIO_W | Output priority for the enqueue |
| unit_busy | output | NUM_UNITS | Unit has both halves occupied |
| pend_ovf | output | 1 | Sticky pending-count overflow |

## Verification
An arrival driven before edge k becomes pending at edge k, and its forward command is registered at edge k+1. A completion driven before edge k yields its enqueue command, the freed half in `unit_busy`, and any overflow flag all at edge k. The bench drives every input at the falling edge and advances a cycle-level expectation model from those inputs and the pre-edge state. It then compares all outputs at the next falling edge, one full edge after the registers update. Directed runs pin the first-dispatch latency, the saturation threshold and the ignored completion. Seeded random runs stress priority contention and weighted bursts.

// File: rtl/tdsp_pkg.sv
package tdsp_pkg;
  localparam int FLOWS_DEF  = 16;
  localparam int UNITS_DEF  = 4;
  localparam int PRIO_W_DEF = 2;
  localparam int WGT_W_DEF  = 4;
  localparam int PEND_W_DEF = 4;
  localparam int OIF_W_DEF  = 2;
endpackage

// File: rtl/tdsp_pend_bank.sv
module tdsp_pend_bank #(
  parameter int NF    = 16,
  parameter int FW    = 4,
  parameter int CNT_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arr_valid,
  input  logic [FW-1:0] arr_flow,
  input  logic          take_valid,
  input  logic [FW-1:0] take_flow,
  output logic [NF-1:0] nonempty,
  output logic          ovf
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [NF-1:0] hit_full;

  for (genvar g = 0; g < NF; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    logic             arr_here;
    logic             inc;
    logic             dec;
    assign arr_here    = arr_valid && (arr_flow == FW'(g));
    assign inc         = arr_here && (cnt != CMAX);
    assign dec         = take_valid && (take_flow == FW'(g));
    assign hit_full[g] = arr_here && (cnt == CMAX);
    assign nonempty[g] = (cnt != '0);
    always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (inc && !dec) cnt <= cnt + 1'b1;
      else if (dec && !inc) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            ovf <= 1'b0;
    else if (|hit_full) ovf <= 1'b1;
  end
endmodule

// File: rtl/tdsp_flow_sel.sv
module tdsp_flow_sel #(
  parameter int NF = 16,
  parameter int FW = 4,
  parameter int PW = 2,
  parameter int WW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NF-1:0]    nonempty,
  input  logic [NF*PW-1:0] cfg_prio,
  input  logic [NF*WW-1:0] cfg_weight,
  input  logic             take,
  output logic             sel_valid,
  output logic [FW-1:0]    sel_flow
);
  logic [FW-1:0] cur;
  logic [WW-1:0] used;
  logic [PW-1:0] top;
  logic [NF-1:0] elig;
  logic [WW-1:0] burst;
  logic          stay;
  logic          found;
  logic [FW-1:0] probe;
  logic [FW-1:0] next_pick;

  always_comb begin
    top = '0;
    for (int f = 0; f < NF; f++) begin
      if (nonempty[f] && (cfg_prio[f*PW +: PW] > top)) top = cfg_prio[f*PW +: PW];
    end
    for (int f = 0; f < NF; f++) begin
      elig[f] = nonempty[f] && (cfg_prio[f*PW +: PW] == top);
    end
    burst = cfg_weight[cur*WW +: WW];
    if (burst == '0) burst = WW'(1);
    stay = elig[cur] && (used < burst);
    found     = 1'b0;
    next_pick = cur;
    probe     = cur;
    for (int i = 1; i <= NF; i++) begin
      probe = cur + FW'(i);
      if (!found && elig[probe]) begin
        found     = 1'b1;
        next_pick = probe;
      end
    end
    sel_valid = |elig;
    sel_flow  = stay ? cur : next_pick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= FW'(NF - 1);
      used <= '1;
    end else if (take) begin
      if (stay) begin
        used <= used + 1'b1;
      end else begin
        cur  <= next_pick;
        used <= WW'(1);
      end
    end
  end
endmodule

// File: rtl/tdsp_unit_track.sv
module tdsp_unit_track #(
  parameter int NU = 4,
  parameter int UW = 2,
  parameter int FW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fill,
  input  logic [FW-1:0]   fill_flow,
  input  logic            done_valid,
  input  logic [UW-1:0]   done_unit,
  output logic            any_avail,
  output logic [UW-1:0]   pick_unit,
  output logic            pick_half,
  output logic            done_hit,
  output logic            done_half,
  output logic [FW-1:0]   done_flow,
  output logic [NU-1:0]   busy,
  output logic [2*NU-1:0] occ_flat
);
  logic [NU-1:0][1:0] occ;
  logic [NU-1:0]      wr_ptr;
  logic [NU-1:0]      rd_ptr;
  logic [FW-1:0]      tag_mem [2*NU];
  logic [NU-1:0]      idle;
  logic [NU-1:0]      open_slot;
  logic               found;

  always_comb begin
    for (int u = 0; u < NU; u++) begin
      idle[u]      = (occ[u] == 2'b00);
      open_slot[u] = (occ[u] != 2'b11);
      busy[u]      = (occ[u] == 2'b11);
    end
    any_avail = |open_slot;
    found     = 1'b0;
    pick_unit = '0;
    for (int u = 0; u < NU; u++) begin
      if (!found && idle[u]) begin
        found     = 1'b1;
        pick_unit = UW'(u);
      end
    end
    for (int u = 0; u < NU; u++) begin
      if (!found && open_slot[u]) begin
        found     = 1'b1;
        pick_unit = UW'(u);
      end
    end
    pick_half = wr_ptr[pick_unit];
  end

  assign done_hit  = done_valid && (occ[done_unit] != 2'b00);
  assign done_half = rd_ptr[done_unit];
  assign done_flow = tag_mem[{done_unit, done_half}];
  assign occ_flat  = occ;

  always_ff @(posedge clk) begin
    if (fill) tag_mem[{pick_unit, pick_half}] <= fill_flow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ    <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      for (int u = 0; u < NU; u++) begin
        if (fill && (pick_unit == UW'(u))) begin
          occ[u][wr_ptr[u]] <= 1'b1;
          wr_ptr[u]         <= ~wr_ptr[u];
        end
        if (done_hit && (done_unit == UW'(u))) begin
          occ[u][rd_ptr[u]] <= 1'b0;
          rd_ptr[u]         <= ~rd_ptr[u];
        end
      end
    end
  end
endmodule

// File: rtl/pkt_task_dispatch.sv
module pkt_task_dispatch
  import tdsp_pkg::*;
#(
  parameter int NUM_FLOWS = FLOWS_DEF,
  parameter int NUM_UNITS = UNITS_DEF,
  parameter int PRIO_W    = PRIO_W_DEF,
  parameter int WGT_W     = WGT_W_DEF,
  parameter int PEND_W    = PEND_W_DEF,
  parameter int OIF_W     = OIF_W_DEF,
  localparam int FW       = $clog2(NUM_FLOWS),
  localparam int UW       = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_FLOWS*PRIO_W-1:0] cfg_prio,
  input  logic [NUM_FLOWS*WGT_W-1:0]  cfg_weight,
  input  logic                       arr_valid,
  input  logic [FW-1:0]              arr_flow,
  input  logic                       done_valid,
  input  logic [UW-1:0]              done_unit,
  input  logic [OIF_W-1:0]           done_oif,
  input  logic [PRIO_W-1:0]          done_oprio,
  output logic                       fwd_valid,
  output logic [FW-1:0]              fwd_flow,
  output logic [UW-1:0]              fwd_unit,
  output logic                       fwd_half,
  output logic                       enq_valid,
  output logic [UW-1:0]              enq_unit,
  output logic                       enq_half,
  output logic [FW-1:0]              enq_flow,
  output logic [OIF_W-1:0]           enq_oif,
  output logic [PRIO_W-1:0]          enq_oprio,
  output logic [NUM_UNITS-1:0]       unit_busy,
  output logic                       pend_ovf
);
  logic [NUM_FLOWS-1:0]   nonempty;
  logic                   sel_valid;
  logic [FW-1:0]          sel_flow;
  logic                   any_avail;
  logic [UW-1:0]          pick_unit;
  logic                   pick_half;
  logic                   done_hit;
  logic                   done_half;
  logic [FW-1:0]          done_flow;
  logic [2*NUM_UNITS-1:0] unit_occ;
  logic                   dispatch;

  assign dispatch = sel_valid && any_avail;

  tdsp_pend_bank #(.NF(NUM_FLOWS), .FW(FW), .CNT_W(PEND_W)) pend_i (
    .clk(clk), .rst(rst),
    .arr_valid(arr_valid), .arr_flow(arr_flow),
    .take_valid(dispatch), .take_flow(sel_flow),
    .nonempty(nonempty), .ovf(pend_ovf)
  );

  tdsp_flow_sel #(.NF(NUM_FLOWS), .FW(FW), .PW(PRIO_W), .WW(WGT_W)) sel_i (
    .clk(clk), .rst(rst),
    .nonempty(nonempty), .cfg_prio(cfg_prio), .cfg_weight(cfg_weight),
    .take(dispatch), .sel_valid(sel_valid), .sel_flow(sel_flow)
  );

  tdsp_unit_track #(.NU(NUM_UNITS), .UW(UW), .FW(FW)) unit_i (
    .clk(clk), .rst(rst),
    .fill(dispatch), .fill_flow(sel_flow),
    .done_valid(done_valid), .done_unit(done_unit),
    .any_avail(any_avail), .pick_unit(pick_unit), .pick_half(pick_half),
    .done_hit(done_hit), .done_half(done_half), .done_flow(done_flow),
    .busy(unit_busy), .occ_flat(unit_occ)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_flow  <= '0;
      fwd_unit  <= '0;
      fwd_half  <= 1'b0;
      enq_valid <= 1'b0;
      enq_unit  <= '0;
      enq_half  <= 1'b0;
      enq_flow  <= '0;
      enq_oif   <= '0;
      enq_oprio <= '0;
    end else begin
      fwd_valid <= dispatch;
      fwd_flow  <= sel_flow;
      fwd_unit  <= pick_unit;
      fwd_half  <= pick_half;
      enq_valid <= done_hit;
      enq_unit  <= done_unit;
      enq_half  <= done_half;
      enq_flow  <= done_flow;
      enq_oif   <= done_oif;
      enq_oprio <= done_oprio;
    end
  end
endmodule

// File: rtl/pkt_task_dispatch_chk.sv
module pkt_task_dispatch_chk #(
  parameter int NU = 4,
  parameter int UW = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            done_valid,
  input logic [UW-1:0]   done_unit,
  input logic            fwd_valid,
  input logic [UW-1:0]   fwd_unit,
  input logic            enq_valid,
  input logic [UW-1:0]   enq_unit,
  input logic [NU-1:0]   unit_busy,
  input logic            pend_ovf,
  input logic [2*NU-1:0] occ_flat
);
  logic [NU-1:0] busy_q;
  logic [1:0]    done_occ;

  assign done_occ = occ_flat[2*done_unit +: 2];

  always_ff @(posedge clk) begin
    if (rst) busy_q <= '0;
    else     busy_q <= unit_busy;
  end

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (!fwd_valid && !enq_valid && (unit_busy == '0) && !pend_ovf));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    pend_ovf |=> pend_ovf);

  assert_fwd_not_full_R4: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> !busy_q[fwd_unit]);

  assert_done_empty_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (done_valid && (done_occ == 2'b00)) |=> !enq_valid);

  assert_done_enqueue_R6: assert property (@(posedge clk) disable iff (rst)
    (done_valid && (done_occ != 2'b00)) |=> (enq_valid && (enq_unit == $past(done_unit))));
endmodule

bind pkt_task_dispatch pkt_task_dispatch_chk #(.NU(NUM_UNITS), .UW(UW)) chk_i (
  .clk(clk), .rst(rst),
  .done_valid(done_valid), .done_unit(done_unit),
  .fwd_valid(fwd_valid), .fwd_unit(fwd_unit),
  .enq_valid(enq_valid), .enq_unit(enq_unit),
  .unit_busy(unit_busy), .pend_ovf(pend_ovf),
  .occ_flat(unit_occ)
);

// File: tb/pkt_task_dispatch_tb_top.sv
module pkt_task_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NF   = 16;
  localparam int NU   = 4;
  localparam int PMAX = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NF*2-1:0] cfg_prio = '0;
  logic [NF*4-1:0] cfg_weight = '0;
  logic          arr_valid = 1'b0;
  logic [3:0]    arr_flow = '0;
  logic          done_valid = 1'b0;
  logic [1:0]    done_unit = '0;
  logic [1:0]    done_oif = '0;
  logic [1:0]    done_oprio = '0;
  logic          fwd_valid, fwd_half, enq_valid, enq_half, pend_ovf;
  logic [3:0]    fwd_flow, enq_flow;
  logic [1:0]    fwd_unit, enq_unit, enq_oif, enq_oprio;
  logic [NU-1:0] unit_busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string tag = "R9";

  int prio [NF];
  int wgt  [NF];
  int m_pend [NF];
  int m_cur, m_used;
  bit m_occ [2*NU];
  int m_tag [2*NU];
  bit m_wr [NU];
  bit m_rd [NU];
  bit m_ovf;
  bit exp_fv, exp_fh, exp_ev, exp_eh;
  int exp_ff, exp_fu, exp_eu, exp_ef, exp_eo, exp_ep;

  pkt_task_dispatch dut_i (
    .clk(clk), .rst(rst), .cfg_prio(cfg_prio), .cfg_weight(cfg_weight),
    .arr_valid(arr_valid), .arr_flow(arr_flow),
    .done_valid(done_valid), .done_unit(done_unit), .done_oif(done_oif), .done_oprio(done_oprio),
    .fwd_valid(fwd_valid), .fwd_flow(fwd_flow), .fwd_unit(fwd_unit), .fwd_half(fwd_half),
    .enq_valid(enq_valid), .enq_unit(enq_unit), .enq_half(enq_half), .enq_flow(enq_flow),
    .enq_oif(enq_oif), .enq_oprio(enq_oprio), .unit_busy(unit_busy), .pend_ovf(pend_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic apply_cfg();
    for (int f = 0; f < NF; f++) begin
      cfg_prio[f*2 +: 2]   = prio[f][1:0];
      cfg_weight[f*4 +: 4] = wgt[f][3:0];
    end
  endtask

  function automatic int busy_exp();
    int b = 0;
    for (int u = 0; u < NU; u++) if (m_occ[2*u] && m_occ[2*u+1]) b |= (1 << u);
    return b;
  endfunction

  task automatic model_step(input bit av, input int af, input bit dv, input int du,
                            input int doif, input int dop);
    int top, pick, u, burst;
    bit stay, anyf, disp, full, hit;
    top = -1;
    for (int f = 0; f < NF; f++) if (m_pend[f] > 0 && prio[f] > top) top = prio[f];
    anyf  = (top >= 0);
    burst = (wgt[m_cur] == 0) ? 1 : wgt[m_cur];
    stay  = anyf && m_pend[m_cur] > 0 && prio[m_cur] == top && m_used < burst;
    pick  = -1;
    if (stay) pick = m_cur;
    else if (anyf) begin
      for (int i = 1; i <= NF; i++) begin
        int j = (m_cur + i) % NF;
        if (pick < 0 && m_pend[j] > 0 && prio[j] == top) pick = j;
      end
    end
    u = -1;
    for (int k = 0; k < NU; k++) if (u < 0 && !m_occ[2*k] && !m_occ[2*k+1]) u = k;
    for (int k = 0; k < NU; k++) if (u < 0 && !(m_occ[2*k] && m_occ[2*k+1])) u = k;
    disp   = anyf && (u >= 0);
    exp_fv = disp;
    if (disp) begin exp_ff = pick; exp_fu = u; exp_fh = m_wr[u]; end
    hit    = dv && (m_occ[2*du] || m_occ[2*du+1]);
    exp_ev = hit;
    if (hit) begin
      exp_eu = du; exp_eh = m_rd[du]; exp_ef = m_tag[2*du + int'(m_rd[du])];
      exp_eo = doif; exp_ep = dop;
    end
    full = av && (m_pend[af] == PMAX);
    if (disp) begin
      m_pend[pick]--;
      m_occ[2*u + int'(m_wr[u])] = 1'b1;
      m_tag[2*u + int'(m_wr[u])] = pick;
      m_wr[u] = ~m_wr[u];
      if (stay) m_used++;
      else begin m_cur = pick; m_used = 1; end
    end
    if (hit) begin
      m_occ[2*du + int'(m_rd[du])] = 1'b0;
      m_rd[du] = ~m_rd[du];
    end
    if (av && !full) m_pend[af]++;
    if (full) m_ovf = 1'b1;
  endtask

  task automatic compare();
    chk(fwd_valid === exp_fv, "R1", "fwd_valid", fwd_valid, exp_fv);
    if (exp_fv && fwd_valid) begin
      chk(fwd_flow == exp_ff, tag, "fwd_flow", fwd_flow, exp_ff);
      chk(fwd_unit == exp_fu, "R4", "fwd_unit", fwd_unit, exp_fu);
      chk(fwd_half == exp_fh, "R5", "fwd_half", fwd_half, exp_fh);
    end
    chk(enq_valid === exp_ev, "R6", "enq_valid", enq_valid, exp_ev);
    if (exp_ev && enq_valid) begin
      chk(enq_unit == exp_eu && enq_half == exp_eh, "R6", "enq_unit/half",
          {enq_unit, enq_half}, exp_eu*2 + int'(exp_eh));
      chk(enq_flow == exp_ef, "R6", "enq_flow", enq_flow, exp_ef);
      chk(enq_oif == exp_eo && enq_oprio == exp_ep, "R6", "enq_oif/oprio",
          {enq_oif, enq_oprio}, exp_eo*4 + exp_ep);
    end
    chk(unit_busy == busy_exp(), "R4", "unit_busy", unit_busy, busy_exp());
    chk(pend_ovf === m_ovf, "R8", "pend_ovf", pend_ovf, m_ovf);
  endtask

  task automatic cycle(input bit av, input int af, input bit dv, input int du,
                       input int doif, input int dop);
    arr_valid  = av;   arr_flow  = af[3:0];
    done_valid = dv;   done_unit = du[1:0];
    done_oif   = doif[1:0]; done_oprio = dop[1:0];
    model_step(av, af, dv, du, doif, dop);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int cnt3;
    void'($urandom(32'd7));
    for (int f = 0; f < NF; f++) begin prio[f] = 0; wgt[f] = 1; m_pend[f] = 0; end
    for (int k = 0; k < 2*NU; k++) begin m_occ[k] = 0; m_tag[k] = 0; end
    for (int u = 0; u < NU; u++) begin m_wr[u] = 0; m_rd[u] = 0; end
    m_cur = NF - 1; m_used = 15; m_ovf = 0;
    apply_cfg();
    repeat (3) @(negedge clk);
    // R9: quiet outputs during reset
    chk(fwd_valid == 0 && enq_valid == 0, "R9", "commands in reset", {fwd_valid, enq_valid}, 0);
    chk(unit_busy == 0 && pend_ovf == 0, "R9", "busy/ovf in reset", {unit_busy, pend_ovf}, 0);
    rst = 1'b0;
    tag = "R1";

    // R7: completion to an empty unit
    cycle(0, 0, 1, 2, 1, 1);
    chk(enq_valid == 0, "R7", "enq after empty done", enq_valid, 0);
    chk(unit_busy == 0, "R7", "busy after empty done", unit_busy, 0);

    // R1: first dispatch latency
    cycle(1, 5, 0, 0, 0, 0);
    chk(fwd_valid == 0, "R1", "fwd one edge after arrival", fwd_valid, 0);
    cycle(0, 0, 0, 0, 0, 0);
    chk(fwd_valid == 1 && fwd_flow == 5, "R1", "fwd flow two edges after arrival", fwd_flow, 5);
    chk(fwd_unit == 0 && fwd_half == 0, "R5", "first target unit/half", {fwd_unit, fwd_half}, 0);

    // R4: fill all units
    for (int i = 0; i < 7; i++) cycle(1, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0);
    chk(unit_busy == 4'hF, "R4", "all units full", unit_busy, 15);
    chk(fwd_valid == 0, "R4", "no dispatch when full", fwd_valid, 0);

    // R8: saturation with all units full
    tag = "R8";
    for (int i = 0; i < 15; i++) cycle(1, 3, 0, 0, 0, 0);
    chk(pend_ovf == 0, "R8", "ovf at limit", pend_ovf, 0);
    cycle(1, 3, 0, 0, 0, 0);
    chk(pend_ovf == 1, "R8", "ovf after arrival at limit", pend_ovf, 1);
    cnt3 = 0;
    for (int i = 0; i < 60; i++) begin
      cycle(0, 0, 1, i % 4, i % 4, 1);
      if (fwd_valid && fwd_flow == 3) cnt3++;
    end
    chk(cnt3 == PMAX, "R8", "dispatches from saturated flow", cnt3, PMAX);
    chk(unit_busy == 0, "R6", "units drained", unit_busy, 0);

    // R2: random priorities and weights under contention
    tag = "R2";
    for (int f = 0; f < NF; f++) begin prio[f] = $urandom % 4; wgt[f] = $urandom % 16; end
    apply_cfg();
    for (int n = 0; n < 1500; n++)
      cycle(($urandom % 4) != 0, $urandom % 8, ($urandom % 5) < 2, $urandom % 4,
            $urandom % 4, $urandom % 4);
    for (int n = 0; n < 500; n++)
      cycle(($urandom % 10) < 3, $urandom % 16, ($urandom % 5) < 3, $urandom % 4,
            $urandom % 4, $urandom % 4);

    // R3: one priority level, weighted bursts
    tag = "R3";
    for (int f = 0; f < NF; f++) begin prio[f] = 2; wgt[f] = $urandom % 16; end
    wgt[1] = 0; wgt[2] = 3;
    apply_cfg();
    for (int n = 0; n < 1500; n++)
      cycle(($urandom % 3) != 0, $urandom % 6, ($urandom % 2) == 0, $urandom % 4,
            $urandom % 4, $urandom % 4);
    for (int n = 0; n < 40; n++) cycle(0, 0, 1, n % 4, 0, 0);

    finish_run();
  end
endmodule